// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an arriving Ethernet frame is wanted. It reads the 48-bit destination address one bit at a time, first bit first, with each byte sent least significant bit first. A start pulse opens each address. A valid strobe marks every cycle that carries an address bit, and idle cycles may fall between bits.

Three checks run side by side while the bits arrive. The first compares the address with a programmable station address, for unicast frames. The second watches for the all-ones broadcast address. The third runs a bit-serial CRC-32 whose top six bits, at the end of the address, pick one bit of a 64-bit multicast hash filter. A promiscuous flag overrides all three. One cycle after the 48th address bit, the block raises a one-cycle done strobe together with its accept decision. The decision then holds until the next start pulse.

Top module: `daf_dest_filter`

## Requirements
- R1: After reset, `done_o` and `accept_o` are 0. Address bits presented before the first start pulse are ignored and produce no done strobe.
- R2: `done_o` is high for exactly one cycle. That cycle is the one after the cycle carrying the 48th valid bit after a start pulse. Cycles with `bit_vld_i` low are not counted.
- R3: An address whose first received bit is 0 is unicast. The k-th received bit (k = 0..47) is compared with `station_addr_i[k]`, so wire byte n maps to bits [8n+7:8n], LSB first. A unicast address is accepted only when all 48 bits match.
- R4: The all-ones address (broadcast) is accepted whatever the hash filter holds.
- R5: For any other address whose first bit is 1 (multicast), a CRC-32 is computed. It uses polynomial 0x04C11DB7 and is preset to all ones. Each bit b updates it as: feedback = crc[31] XOR b, crc shifts left by one, and the polynomial is XORed in when feedback is 1. The index is crc[31:26] after all 48 bits, and the frame is accepted exactly when `hash_filter_i[index]` is 1.
- R6: With an all-zero hash filter and promiscuous mode off, every multicast address other than broadcast is rejected.
- R7: When `promisc_i` is 1 at the 48th bit, the address is accepted regardless of the other checks.
- R8: Valid bits after the 48th are ignored until the next start pulse. They cause no further done strobe and leave `accept_o` unchanged.
- R9: A start pulse clears all internal state, even in the middle of an address. `accept_o` drops to 0 on the following cycle, and bit counting restarts from zero. A bit strobed in the same cycle as the start pulse is ignored.
- R10: `accept_o` changes only in the cycle that `done_o` is high or in the cycle after a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start pulse; opens a new address |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Serial destination address bit |
| station_addr_i | input | 48 | Station address; bit 0 must be 0 |
| hash_filter_i | input | 64 | Multicast hash filter |
| promisc_i | input | 1 | Accept every address |
| done_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Accept decision, held until the next start pulse |

## Verification
The assertions assume that `station_addr_i`, `hash_filter_i` and `promisc_i` are stable during the cycle of the 48th bit, since the decision is formed from them in that cycle. The assertions also assume that the start pulse lasts a single cycle. The bench changes these configuration inputs only between addresses, while the block is idle, and drives every start pulse for exactly one cycle. Every stimulus change is made on the falling clock edge.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int DAF_ADDR_W   = 48;
    localparam int DAF_FILT_W   = 64;
    localparam int DAF_CRC_W    = 32;
    localparam logic [31:0] DAF_CRC_POLY = 32'h04C1_1DB7;

    typedef struct packed {
        logic done;
        logic accept;
    } daf_verdict_t;
endpackage

// File: rtl/daf_crc_serial.sv
module daf_crc_serial #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_q_o,
    output logic [W-1:0] crc_next_o
);
    typedef struct packed {
        logic [W-1:0] crc;
    } crc_state_t;

    crc_state_t st_d, st_q;
    logic       fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.crc[W-1] ^ bit_i;
        if (clr_i) begin
            st_d.crc = '1;
        end else if (en_i) begin
            st_d.crc = {st_q.crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.crc <= '1;
        else        st_q     <= st_d;
    end

    assign crc_q_o    = st_q.crc;
    assign crc_next_o = st_d.crc;

    // R5: an idle, uncleared cycle leaves the running remainder alone
    assert_crc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(crc_q_o));
endmodule

// File: rtl/daf_addr_tracker.sv
module daf_addr_tracker #(
    parameter int AW = 48,
    localparam int CW = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof_i,
    input  logic          vld_i,
    input  logic          bit_i,
    input  logic [AW-1:0] station_i,
    output logic          take_o,
    output logic          last_o,
    output logic          group_nxt_o,
    output logic          mism_nxt_o,
    output logic          nonone_nxt_o
);
    localparam logic [CW-1:0] FULL = CW'(AW);
    localparam logic [CW-1:0] LAST = CW'(AW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          group;
        logic          mism;
        logic          nonone;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       ref_bit;

    always_comb begin
        st_d    = st_q;
        take_o  = vld_i && !sof_i && (st_q.cnt < FULL);
        last_o  = take_o && (st_q.cnt == LAST);
        ref_bit = (st_q.cnt < FULL) ? station_i[st_q.cnt] : 1'b0;
        if (sof_i) begin
            st_d.cnt    = '0;
            st_d.group  = 1'b0;
            st_d.mism   = 1'b0;
            st_d.nonone = 1'b0;
        end else if (take_o) begin
            if (st_q.cnt == '0) st_d.group = bit_i;
            st_d.mism   = st_q.mism | (bit_i != ref_bit);
            st_d.nonone = st_q.nonone | !bit_i;
            st_d.cnt    = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= FULL;
            st_q.group  <= 1'b0;
            st_q.mism   <= 1'b0;
            st_q.nonone <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign group_nxt_o  = st_d.group;
    assign mism_nxt_o   = st_d.mism;
    assign nonone_nxt_o = st_d.nonone;

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    assert_idle_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL && !sof_i) |=> st_q.cnt == FULL);
endmodule

// File: rtl/daf_dest_filter.sv
module daf_dest_filter
    import daf_pkg::*;
#(
    parameter int ADDR_W = DAF_ADDR_W,
    parameter int FILT_W = DAF_FILT_W,
    parameter int CRC_W  = DAF_CRC_W,
    parameter logic [CRC_W-1:0] CRC_POLY = DAF_CRC_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic [ADDR_W-1:0] station_addr_i,
    input  logic [FILT_W-1:0] hash_filter_i,
    input  logic              promisc_i,
    output logic              done_o,
    output logic              accept_o
);
    localparam int IDX_W = $clog2(FILT_W);

    logic             take, last, group_n, mism_n, nonone_n, bcast;
    logic [CRC_W-1:0] crc_q, crc_n;
    logic [IDX_W-1:0] hash_idx;
    daf_verdict_t     vd_d, vd_q;

    daf_addr_tracker #(.AW(ADDR_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof_i        (sof_i),
        .vld_i        (bit_vld_i),
        .bit_i        (bit_i),
        .station_i    (station_addr_i),
        .take_o       (take),
        .last_o       (last),
        .group_nxt_o  (group_n),
        .mism_nxt_o   (mism_n),
        .nonone_nxt_o (nonone_n)
    );

    daf_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sof_i),
        .en_i       (take),
        .bit_i      (bit_i),
        .crc_q_o    (crc_q),
        .crc_next_o (crc_n)
    );

    always_comb begin
        vd_d     = vd_q;
        bcast    = !nonone_n;
        hash_idx = crc_n[CRC_W-1 -: IDX_W];
        if (sof_i) begin
            vd_d.done   = 1'b0;
            vd_d.accept = 1'b0;
        end else begin
            vd_d.done = last;
            if (last) begin
                vd_d.accept = promisc_i |
                    (group_n ? (bcast | hash_filter_i[hash_idx]) : !mism_n);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q.done   <= 1'b0;
            vd_q.accept <= 1'b0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign done_o   = vd_q.done;
    assign accept_o = vd_q.accept;

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(promisc_i)) |-> accept_o);
    assert_bcast_accepts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(bcast) && $past(group_n)) |-> accept_o);
    assert_ucast_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(group_n) && $past(mism_n) && !$past(promisc_i)) |-> !accept_o);
    assert_accept_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(sof_i)) |-> $stable(accept_o));
endmodule

// File: tb/tb_daf_dest_filter.sv
module tb_daf_dest_filter;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] POLY = 32'h04C1_1DB7;
    localparam logic [47:0] STATION = 48'h5A3C_1234_5678;
    localparam logic [47:0] MCAST   = 48'h0000_5E00_0001;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        bit_vld_i = 1'b0;
    logic        bit_i = 1'b0;
    logic [47:0] station_addr_i = STATION;
    logic [63:0] hash_filter_i = '0;
    logic        promisc_i = 1'b0;
    logic        done_o, accept_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    daf_dest_filter dut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .station_addr_i(station_addr_i),
        .hash_filter_i(hash_filter_i), .promisc_i(promisc_i),
        .done_o(done_o), .accept_o(accept_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            summary();
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_index(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int k = 0; k < 48; k++) begin
            logic fb = c[31] ^ a[k];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        return c[31:26];
    endfunction

    function automatic logic model(input logic [47:0] a);
        if (promisc_i) return 1'b1;
        if (a[0]) return (a == BCAST) || hash_filter_i[hash_index(a)];
        return a == station_addr_i;
    endfunction

    task automatic pulse_sof();
        @(negedge clk);
        sof_i = 1'b1; bit_vld_i = 1'b0;
        @(negedge clk);
        sof_i = 1'b0;
    endtask

    // Sends one address after a start pulse and checks strobe timing and decision.
    task automatic send_addr(input logic [47:0] a, input bit gaps, input string req);
        bit early = 1'b0;
        pulse_sof();
        for (int k = 0; k < 48; k++) begin
            if (gaps && (k % 5 == 2)) begin
                bit_vld_i = 1'b0;
                @(negedge clk);
                if (done_o) early = 1'b1;
            end
            bit_vld_i = 1'b1; bit_i = a[k];
            @(negedge clk);
            if (k < 47 && done_o) early = 1'b1;
        end
        bit_vld_i = 1'b0;
        check({req, " R2 no early done"}, early, 0);
        check({req, " R2 done after 48th bit"}, done_o, 1);
        check({req, " decision"}, accept_o, model(a));
        @(negedge clk);
        check({req, " R2 done single cycle"}, done_o, 0);
        check({req, " R10 decision held"}, accept_o, model(a));
    endtask

    task automatic t_reset();
        check("R1 done at reset", done_o, 0);
        check("R1 accept at reset", accept_o, 0);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            bit_vld_i = 1'b1; bit_i = 1'b1;
            if (done_o) check("R1 stray bits before start", done_o, 0);
        end
        bit_vld_i = 1'b0;
        @(negedge clk);
        check("R1 no done before start", done_o, 0);
    endtask

    task automatic t_unicast();
        send_addr(STATION, 0, "R3 unicast match");
        check("R3 unicast match accepted", accept_o, 1);
        send_addr(STATION ^ 48'h8000_0000_0000, 0, "R3 last bit differs");
        check("R3 mismatch rejected", accept_o, 0);
        send_addr(STATION ^ 48'h0000_0000_0100, 0, "R3 byte1 lsb differs");
        check("R3 byte1 mismatch rejected", accept_o, 0);
    endtask

    task automatic t_broadcast();
        hash_filter_i = '0;
        send_addr(BCAST, 0, "R4 broadcast");
        check("R4 broadcast with empty filter", accept_o, 1);
    endtask

    task automatic t_multicast();
        logic [5:0] idx = hash_index(MCAST);
        hash_filter_i = 64'd1 << idx;
        send_addr(MCAST, 0, "R5 hash bit set");
        check("R5 selected bit set accepts", accept_o, 1);
        hash_filter_i = ~(64'd1 << idx);
        send_addr(MCAST, 0, "R5 hash bit clear");
        check("R5 selected bit clear rejects", accept_o, 0);
        hash_filter_i = '0;
        send_addr(48'h3300_0000_0001 | 48'h0000_00AB_0000, 0, "R6 empty filter");
        check("R6 empty filter rejects multicast", accept_o, 0);
    endtask

    task automatic t_promisc();
        promisc_i = 1'b1;
        send_addr(48'h1111_2222_3332, 0, "R7 promisc foreign unicast");
        check("R7 promisc accepts", accept_o, 1);
        promisc_i = 1'b0;
    endtask

    task automatic t_gaps();
        send_addr(STATION, 1, "R2 gapped valid");
    endtask

    task automatic t_overrun();
        send_addr(STATION, 0, "R8 pre");
        for (int k = 0; k < 12; k++) begin
            bit_vld_i = 1'b1; bit_i = ~bit_i;
            @(negedge clk);
            if (done_o) check("R8 extra bits raise no done", done_o, 0);
        end
        bit_vld_i = 1'b0;
        @(negedge clk);
        check("R8 no done after extra bits", done_o, 0);
        check("R8 accept unchanged", accept_o, 1);
    endtask

    task automatic t_restart();
        send_addr(STATION, 0, "R9 pre");
        pulse_sof();
        check("R9 start clears accept", accept_o, 0);
        for (int k = 0; k < 20; k++) begin
            bit_vld_i = 1'b1; bit_i = ~STATION[k];
            @(negedge clk);
        end
        bit_vld_i = 1'b0;
        send_addr(STATION, 0, "R9 restart from zero");
        check("R9 full address after restart accepted", accept_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_broadcast();
        t_multicast();
        t_promisc();
        t_gaps();
        t_overrun();
        t_restart();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule